// File: doc/BRIEF.md
# Cascadable Serial Wiper Control Port

This block is the serial control port of a six-channel digital potentiometer, written as synchronous logic on a fast system clock. An external controller drives three slow inputs: a port enable, a serial clock and serial data. While the port is enabled, serial data shifts through a 48-bit transfer register. A cascade output presents the register's far end, so several devices can be daisy-chained with each output feeding the next device's data input. A chain of N devices needs 48×N serial clocks for a complete transfer.

Each time the port opens, the transfer register is loaded from the six live 8-bit wiper settings. Each time it closes, the register contents become the new settings. If the controller loops the last cascade output back to the first data input, the settings can be read out without being disturbed. Clocking the full 48 bits per device returns every bit to its starting place, so closing the port rewrites the same values.

Top module: `wiper_serial_port`

## Requirements
- R1: While `rst` is high, and after it is released, every wiper reads 0x80 and `cascade_o` is 0 until the port is first opened.
- R2: While `port_en_i` is low, toggling `sclk_i` and `sdata_i` changes neither `cascade_o` nor `wipers_o`.
- R3: A rising `port_en_i` loads the transfer register from the wipers. Within 4 system clocks, and before any serial clock, `cascade_o` shows bit 0 of wiper 0.
- R4: Each rising `sclk_i` while enabled moves `sdata_i` into the near end of the register and presents the next bit on `cascade_o`. After the port opens, the bits appear in the order wiper 0 bit 0 through bit 7, then wiper 1 bit 0, and on up to wiper 5 bit 7.
- R5: A falling `port_en_i` commits the register to the wipers. After exactly 48 serial clocks, the first data bit sent becomes bit 0 of `wipers_o` and the 48th becomes bit 47. Wiper k occupies `wipers_o[8k+7:8k]`.
- R6: With `sdata_i` fed from `cascade_o`, 48 serial clocks followed by closing the port leave every wiper unchanged.
- R7: Closing the port after a count that is not a multiple of 48, zero included, commits whatever the register holds at that moment.
- R8: `cascade_o` always carries the register's far-end bit, including after the port closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en_i | input | 1 | Asynchronous port enable; a rising edge opens a transfer and a falling edge commits it |
| sclk_i | input | 1 | Asynchronous serial clock; data moves on its rising edge |
| sdata_i | input | 1 | Asynchronous serial data input |
| cascade_o | output | 1 | Far end of the transfer register, for chaining or readback |
| wipers_o | output | 48 | Six 8-bit wiper settings; wiper k at bits 8k+7 to 8k |

## Verification
The bench writes a pattern whose bits differ across all six wipers. A design with reversed bit or wiper ordering would therefore commit a permuted value and show a wrong cascade sequence. A loopback readback checks that circulating the data leaves the settings intact; an off-by-one shift or a missing preload would corrupt them. Serial clocks applied while the port is disabled would visibly move the cascade output if they were not ignored. Closes after zero and after five clocks expose a design that commits only on full counts, or that fails to commit at all.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  localparam int unsigned WSP_CHANNELS = 6;
  localparam int unsigned WSP_BITS     = 8;
  localparam logic [7:0]  WSP_MIDSCALE = 8'h80;
  localparam int unsigned WSP_SYNC     = 2;
endpackage

// File: rtl/wsp_sync.sv
module wsp_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/wsp_shifter.sv
module wsp_shifter #(
  parameter int unsigned WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  input  logic             din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[WIDTH-2:0], din};
  end
endmodule

// File: rtl/wsp_wiper_bank.sv
module wsp_wiper_bank #(
  parameter int unsigned CHANNELS = 6,
  parameter int unsigned BITS     = 8,
  parameter logic [7:0]  INIT     = 8'h80
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     commit,
  input  logic [CHANNELS*BITS-1:0] commit_val,
  output logic [CHANNELS*BITS-1:0] wipers
);
  for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)         wipers[k*BITS +: BITS] <= INIT[BITS-1:0];
      else if (commit) wipers[k*BITS +: BITS] <= commit_val[k*BITS +: BITS];
    end
  end
endmodule

// File: rtl/wiper_serial_port.sv
module wiper_serial_port
  import wsp_pkg::*;
#(
  parameter int unsigned CHANNELS    = WSP_CHANNELS,
  parameter int unsigned BITS        = WSP_BITS,
  parameter int unsigned SYNC_STAGES = WSP_SYNC,
  parameter logic [7:0]  INIT        = WSP_MIDSCALE
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     port_en_i,
  input  logic                     sclk_i,
  input  logic                     sdata_i,
  output logic                     cascade_o,
  output logic [CHANNELS*BITS-1:0] wipers_o
);
  localparam int unsigned REG_W = CHANNELS * BITS;

  logic [2:0]       sync_q;
  logic             en_s, sclk_s, sdat_s;
  logic             en_q, sclk_q;
  logic             load_pulse, shift_pulse, commit_pulse;
  logic [REG_W-1:0] preload, commit_val, shreg;

  wsp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({port_en_i, sclk_i, sdata_i}),
    .q   (sync_q)
  );
  assign {en_s, sclk_s, sdat_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      en_q   <= en_s;
      sclk_q <= sclk_s;
    end
  end

  assign load_pulse   = en_s & ~en_q;
  assign commit_pulse = ~en_s & en_q;
  assign shift_pulse  = en_s & en_q & sclk_s & ~sclk_q;

  // Wiper 0 bit 0 sits at the output end; flat index i maps to REG_W-1-i.
  for (genvar i = 0; i < REG_W; i++) begin : g_map
    assign preload[REG_W-1-i] = wipers_o[i];
    assign commit_val[i]      = shreg[REG_W-1-i];
  end

  wsp_shifter #(.WIDTH(REG_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load_pulse),
    .load_val (preload),
    .shift    (shift_pulse),
    .din      (sdat_s),
    .q        (shreg)
  );

  wsp_wiper_bank #(.CHANNELS(CHANNELS), .BITS(BITS), .INIT(INIT)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit_pulse),
    .commit_val (commit_val),
    .wipers     (wipers_o)
  );

  assign cascade_o = shreg[REG_W-1];
endmodule

// File: rtl/wsp_checker.sv
module wsp_checker #(
  parameter int unsigned REG_W = 48,
  parameter int unsigned BITS  = 8,
  parameter logic [7:0]  INIT  = 8'h80
) (
  input logic             clk,
  input logic             rst,
  input logic             en_s,
  input logic             sdat_s,
  input logic             load_pulse,
  input logic             shift_pulse,
  input logic             commit_pulse,
  input logic [REG_W-1:0] shreg,
  input logic             cascade_o,
  input logic [REG_W-1:0] wipers_o
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: wipers sit at midscale in the cycle after a reset edge
  always_ff @(posedge clk) begin
    if (rst_q) begin
      p_reset_mid_r1: assert (wipers_o == {(REG_W/BITS){INIT[BITS-1:0]}})
        else $error("R1: wipers not at midscale after reset");
    end
  end

  p_disabled_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> $stable(shreg));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> (cascade_o == $past(wipers_o[0])));

  p_shift_r4: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |=> (shreg[0] == $past(sdat_s)) && (cascade_o == $past(shreg[REG_W-2])));

  p_commit_r5: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |=> (wipers_o[0] == $past(shreg[REG_W-1])) &&
                     (wipers_o[REG_W-1] == $past(shreg[0])));

  p_wiper_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !commit_pulse |=> $stable(wipers_o));
endmodule

bind wiper_serial_port wsp_checker #(.REG_W(REG_W), .BITS(BITS), .INIT(INIT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .en_s         (en_s),
  .sdat_s       (sdat_s),
  .load_pulse   (load_pulse),
  .shift_pulse  (shift_pulse),
  .commit_pulse (commit_pulse),
  .shreg        (shreg),
  .cascade_o    (cascade_o),
  .wipers_o     (wipers_o)
);

// File: tb/wiper_serial_port_test.sv
module wiper_serial_port_test;
  localparam int W = 48;
  localparam logic [W-1:0] MID = {6{8'h80}};
  localparam logic [W-1:0] PAT = 48'h5A_C3_17_E8_36_F1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_en_i = 1'b0, sclk_i = 1'b0, sdata_i = 1'b0;
  logic cascade_o;
  logic [W-1:0] wipers_o;

  always #4 clk = ~clk;

  wiper_serial_port uut (
    .clk(clk), .rst(rst), .port_en_i(port_en_i), .sclk_i(sclk_i),
    .sdata_i(sdata_i), .cascade_o(cascade_o), .wipers_o(wipers_o)
  );

  typedef struct { bit is_wiper; string req; logic [W-1:0] exp; } item_t;
  item_t exp_q[$];
  event  chk_ev;
  int checks = 0, errors = 0;
  logic [W-1:0] model;

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) rev[W-1-i] = v[i];
  endfunction

  function automatic void push(input bit is_w, input string req, input logic [W-1:0] e);
    item_t it;
    it.is_wiper = is_w; it.req = req; it.exp = e;
    exp_q.push_back(it);
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_now();
    @(negedge clk);
    ->chk_ev;
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (it.is_wiper) begin
          if (wipers_o !== it.exp) begin
            errors++;
            $display("FAIL %s wipers actual=%h expected=%h", it.req, wipers_o, it.exp);
          end
        end else if (cascade_o !== it.exp[0]) begin
          errors++;
          $display("FAIL %s cascade actual=%b expected=%b", it.req, cascade_o, it.exp[0]);
        end
      end
    end
  end

  task automatic open_port();
    port_en_i = 1'b1; waitc(6); model = rev(wipers_o);
  endtask

  task automatic close_port();
    port_en_i = 1'b0; waitc(6);
  endtask

  task automatic shift_bit(input logic d);
    sdata_i = d; waitc(4);
    sclk_i = 1'b1; waitc(6);
    sclk_i = 1'b0; waitc(4);
    model = {model[W-2:0], d};
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    logic held;
    waitc(5);
    rst = 1'b0; waitc(2);
    push(1, "R1", MID); push(0, "R1", '0); check_now();

    // Write PAT, checking the old contents stream out in order
    open_port();
    push(0, "R3", {47'b0, MID[0]}); check_now();
    for (int j = 0; j < W; j++) begin
      push(0, "R4", {47'b0, MID[j]}); check_now();
      shift_bit(PAT[j]);
    end
    close_port();
    push(1, "R5", PAT); push(0, "R8", {47'b0, model[W-1]}); check_now();

    // Loopback readback
    open_port();
    push(0, "R3", {47'b0, PAT[0]}); check_now();
    for (int j = 0; j < W; j++) begin
      push(0, "R4", {47'b0, PAT[j]}); check_now();
      shift_bit(cascade_o);
    end
    close_port();
    push(1, "R6", PAT); check_now();

    // Disabled port ignores serial activity
    held = cascade_o;
    for (int j = 0; j < 10; j++) begin
      sdata_i = j[0]; waitc(3);
      sclk_i = 1'b1; waitc(5);
      sclk_i = 1'b0; waitc(3);
    end
    push(0, "R2", {47'b0, held}); push(1, "R2", PAT); check_now();

    // Zero-clock transfer commits the reloaded contents
    open_port(); close_port();
    push(1, "R7", PAT); push(0, "R8", {47'b0, PAT[0]}); check_now();

    // Partial transfer of five ones
    open_port();
    for (int j = 0; j < 5; j++) shift_bit(1'b1);
    push(0, "R4", {47'b0, PAT[5]}); check_now();
    close_port();
    push(1, "R7", rev(model)); push(0, "R8", {47'b0, model[W-1]}); check_now();

    // Reset returns to midscale
    rst = 1'b1; waitc(3); rst = 1'b0; waitc(2);
    push(1, "R1", MID); push(0, "R1", '0); check_now();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule